// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

A bank of 32 general-purpose lines sitting behind a small word-addressed register bus. Every line has an output latch, a direction bit and an input inversion bit. Pin inputs are brought into the clock domain through two-flop synchronisers. Each synchronised value is then XORed with the line's inversion bit, and the result is the line's adjusted input.

The adjusted input feeds two interrupt paths. In the level path, the adjusted input itself is the cause. In the edge path, a 0-to-1 change of the adjusted input sets a sticky cause bit. Each path has its own mask register. Software acknowledges edge causes by writing zeros into the bits it wants cleared. Masked causes from both paths are ORed in groups of eight lines, which gives four summary interrupt outputs. A handler reads the group outputs first and then reads the adjusted input and edge cause registers to find the line.

The bus addresses 32-bit words, so the word index is the byte offset divided by four. Words 0 to 7 are mapped; every higher index reads as zero.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the direction register reads all ones (every line is an input) and `pin_oe` is 0. The output latch, inversion, edge cause, edge mask and level mask registers all read 0, and `irq_grp` is 0.
- R2: Word 1 is the direction register. A bit of 0 makes the line an output: `pin_oe` is 1 for that line and `pin_out` drives the matching bit of the output latch (word 0). A bit of 1 releases the line (`pin_oe` is 0).
- R3: Reading word 4 returns each line's synchronised pin value XOR its inversion bit (word 3). A pin change shows in this value after two clock edges.
- R4: Level path: a line whose level mask bit (word 7) is 1 raises its group output whenever its adjusted input is 1, and stops raising it when the adjusted input returns to 0.
- R5: Edge path: when a line's adjusted input goes from 0 to 1 between two clocks, its edge cause bit (word 5) is set and stays set until it is cleared. An edge cause bit raises its group output only while the matching edge mask bit (word 6) is 1. With inversion 1, a falling pin sets the bit and a rising pin does not.
- R6: A write to word 5 clears each cause bit written as 0 and leaves each bit written as 1 unchanged.
- R7: If a new edge on a line arrives in the same cycle as a write that would clear its cause bit, the bit ends up set.
- R8: Line i contributes only to `irq_grp[i/8]`: lines 0-7 to bit 0, 8-15 to bit 1, 16-23 to bit 2 and 24-31 to bit 3.
- R9: Word 2 (blink enable) reads back what was written and has no effect on `pin_out` or `pin_oe`. Reads of word indices 8 and above return 0.
- R10: Words 0, 1, 3, 6 and 7 read back the last value written to them. `rdata` updates on the clock edge that samples `rd_en`.
- R11: A cause bit whose mask bit is 0 never raises an interrupt. With both mask registers zero, `irq_grp` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output latch value driven to the pads |
| pin_oe | output | 32 | Per-line output enable, 1 = drive |
| irq_grp | output | 4 | Summary interrupts, one per group of eight lines |

## Verification
A wrong edge cause bit shows in two places. A read of word 5 returns it one clock later. If the line's edge mask is set, the group output shows it in the same cycle the bit is registered. A lost or duplicated edge would therefore show up as a cause that survives an acknowledge or never appears. A wrong synchroniser stage or a wrong inversion bit shows in the word 4 read and, through the level path, on `irq_grp` as soon as the adjusted input settles two clocks after a pin change. A direction or output latch error reaches `pin_oe` and `pin_out` on the clock edge right after the write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    // Word indices of the register file (byte offset = index * 4)
    localparam int unsigned IDX_OUT    = 0;
    localparam int unsigned IDX_DIR    = 1;
    localparam int unsigned IDX_BLINK  = 2;
    localparam int unsigned IDX_INV    = 3;
    localparam int unsigned IDX_DIN    = 4;
    localparam int unsigned IDX_ECAUSE = 5;
    localparam int unsigned IDX_EMASK  = 6;
    localparam int unsigned IDX_LMASK  = 7;
    localparam int unsigned NUM_REGS   = 8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  din_val,
    input  logic [WIDTH-1:0]  ecause_val,
    output logic [WIDTH-1:0]  out_val,
    output logic [WIDTH-1:0]  dir_val,
    output logic [WIDTH-1:0]  inv_val,
    output logic [WIDTH-1:0]  emask_val,
    output logic [WIDTH-1:0]  lmask_val,
    output logic              ecause_wr,
    output logic [WIDTH-1:0]  rdata
);
    typedef struct packed {
        logic [WIDTH-1:0] outv;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] blink;
        logic [WIDTH-1:0] inv;
        logic [WIDTH-1:0] emask;
        logic [WIDTH-1:0] lmask;
        logic [WIDTH-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;
    logic [WIDTH-1:0] rd_mux;

    always_comb begin
        st_d      = st_q;
        ecause_wr = 1'b0;
        rd_mux    = '0;
        unique case (addr)
            ADDR_W'(IDX_OUT):    rd_mux = st_q.outv;
            ADDR_W'(IDX_DIR):    rd_mux = st_q.dir;
            ADDR_W'(IDX_BLINK):  rd_mux = st_q.blink;
            ADDR_W'(IDX_INV):    rd_mux = st_q.inv;
            ADDR_W'(IDX_DIN):    rd_mux = din_val;
            ADDR_W'(IDX_ECAUSE): rd_mux = ecause_val;
            ADDR_W'(IDX_EMASK):  rd_mux = st_q.emask;
            ADDR_W'(IDX_LMASK):  rd_mux = st_q.lmask;
            default:             rd_mux = '0;
        endcase
        if (wr_en) begin
            unique case (addr)
                ADDR_W'(IDX_OUT):    st_d.outv  = wdata;
                ADDR_W'(IDX_DIR):    st_d.dir   = wdata;
                ADDR_W'(IDX_BLINK):  st_d.blink = wdata;
                ADDR_W'(IDX_INV):    st_d.inv   = wdata;
                ADDR_W'(IDX_ECAUSE): ecause_wr  = 1'b1;
                ADDR_W'(IDX_EMASK):  st_d.emask = wdata;
                ADDR_W'(IDX_LMASK):  st_d.lmask = wdata;
                default: ;
            endcase
        end
        if (rd_en) begin
            st_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.dir   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_val   = st_q.outv;
    assign dir_val   = st_q.dir;
    assign inv_val   = st_q.inv;
    assign emask_val = st_q.emask;
    assign lmask_val = st_q.lmask;
    assign rdata     = st_q.rdata;
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned GROUP = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [WIDTH-1:0]         sync_val,
    input  logic [WIDTH-1:0]         inv_val,
    input  logic [WIDTH-1:0]         emask_val,
    input  logic [WIDTH-1:0]         lmask_val,
    input  logic                     clr_en,
    input  logic [WIDTH-1:0]         clr_bits,
    output logic [WIDTH-1:0]         din_val,
    output logic [WIDTH-1:0]         ecause_val,
    output logic [WIDTH-1:0]         rise,
    output logic [WIDTH/GROUP-1:0]   irq
);
    localparam int unsigned NGRP = WIDTH / GROUP;

    typedef struct packed {
        logic [WIDTH-1:0] prev;
        logic [WIDTH-1:0] cause;
    } sense_t;

    sense_t st_d, st_q;
    logic [WIDTH-1:0] keep;
    logic [WIDTH-1:0] pending;

    assign din_val = sync_val ^ inv_val;

    always_comb begin
        rise       = din_val & ~st_q.prev;
        keep       = clr_en ? clr_bits : '1;
        st_d.prev  = din_val;
        // a fresh edge overrides a clearing write
        st_d.cause = (st_q.cause & keep) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ecause_val = st_q.cause;
    assign pending    = (din_val & lmask_val) | (st_q.cause & emask_val);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign irq[g] = |pending[g*GROUP +: GROUP];
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned GROUP  = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [WIDTH-1:0]       wdata,
    output logic [WIDTH-1:0]       rdata,
    input  logic [WIDTH-1:0]       pin_in,
    output logic [WIDTH-1:0]       pin_out,
    output logic [WIDTH-1:0]       pin_oe,
    output logic [WIDTH/GROUP-1:0] irq_grp
);
    logic [WIDTH-1:0] sync_w;
    logic [WIDTH-1:0] din_w;
    logic [WIDTH-1:0] ecause_w;
    logic [WIDTH-1:0] rise_w;
    logic [WIDTH-1:0] out_w;
    logic [WIDTH-1:0] dir_w;
    logic [WIDTH-1:0] inv_w;
    logic [WIDTH-1:0] emask_w;
    logic [WIDTH-1:0] lmask_w;
    logic             ecause_wr_w;

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_w)
    );

    gpio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .din_val    (din_w),
        .ecause_val (ecause_w),
        .out_val    (out_w),
        .dir_val    (dir_w),
        .inv_val    (inv_w),
        .emask_val  (emask_w),
        .lmask_val  (lmask_w),
        .ecause_wr  (ecause_wr_w),
        .rdata      (rdata)
    );

    gpio_irq_sense #(.WIDTH(WIDTH), .GROUP(GROUP)) u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_val   (sync_w),
        .inv_val    (inv_w),
        .emask_val  (emask_w),
        .lmask_val  (lmask_w),
        .clr_en     (ecause_wr_w),
        .clr_bits   (wdata),
        .din_val    (din_w),
        .ecause_val (ecause_w),
        .rise       (rise_w),
        .irq        (irq_grp)
    );

    assign pin_out = out_w;
    assign pin_oe  = ~dir_w;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned GROUP  = 8,
    parameter int unsigned ADDR_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      addr,
    input logic [WIDTH-1:0]       wdata,
    input logic [WIDTH-1:0]       pin_oe,
    input logic [WIDTH/GROUP-1:0] irq_grp,
    input logic [WIDTH-1:0]       ecause,
    input logic [WIDTH-1:0]       rise,
    input logic [WIDTH-1:0]       emask,
    input logic [WIDTH-1:0]       lmask
);
    logic cause_wr;
    logic dir_wr;
    assign cause_wr = wr_en && (addr == ADDR_W'(IDX_ECAUSE));
    assign dir_wr   = wr_en && (addr == ADDR_W'(IDX_DIR));

    AST_CAUSE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ecause & ~$past(ecause) & ~$past(rise)) == '0)); // R5

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_wr |=> ((ecause & $past(ecause)) == $past(ecause))); // R5

    AST_CLEAR_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        cause_wr |=> ((ecause & ~$past(wdata) & ~$past(rise)) == '0)); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cause_wr |=> ((ecause & $past(rise)) == $past(rise))); // R7

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (emask == '0 && lmask == '0) |-> (irq_grp == '0)); // R11

    AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> (pin_oe == ~$past(wdata))); // R2
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.WIDTH(WIDTH), .GROUP(GROUP), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .pin_oe  (pin_oe),
    .irq_grp (irq_grp),
    .ecause  (ecause_w),
    .rise    (rise_w),
    .emask   (emask_w),
    .lmask   (lmask_w)
);

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;
    import gpio_bank_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic [3:0]  irq_grp;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gpio_irq_bank dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .irq_grp (irq_grp)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int unsigned idx, input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'(idx); wdata = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input int unsigned idx, output logic [31:0] val);
        @(negedge clk);
        rd_en = 1'b1; addr = 4'(idx);
        @(negedge clk);
        rd_en = 1'b0;
        val = rdata;
    endtask

    task automatic settle_pins();
        repeat (3) @(negedge clk);
    endtask

    task automatic quiet_all();
        pin_in = '0;
        bus_write(IDX_INV, '0);
        bus_write(IDX_EMASK, '0);
        bus_write(IDX_LMASK, '0);
        settle_pins();
        bus_write(IDX_ECAUSE, '0);
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        bus_read(IDX_DIR, v);    check("R1 dir reset", v, 32'hFFFF_FFFF);
        check("R1 pin_oe reset", pin_oe, '0);
        bus_read(IDX_OUT, v);    check("R1 out reset", v, '0);
        bus_read(IDX_INV, v);    check("R1 inv reset", v, '0);
        bus_read(IDX_ECAUSE, v); check("R1 cause reset", v, '0);
        bus_read(IDX_EMASK, v);  check("R1 emask reset", v, '0);
        bus_read(IDX_LMASK, v);  check("R1 lmask reset", v, '0);
        check("R1 irq reset", {28'd0, irq_grp}, '0);
    endtask

    task automatic t_regs_dir();
        logic [31:0] v;
        bus_write(IDX_OUT, 32'h0F0F_0F0F);
        bus_write(IDX_DIR, 32'hFFFF_00FF);
        check("R2 pin_oe", pin_oe, 32'h0000_FF00);
        check("R2 pin_out", pin_out, 32'h0F0F_0F0F);
        bus_read(IDX_OUT, v); check("R10 out readback", v, 32'h0F0F_0F0F);
        bus_read(IDX_DIR, v); check("R10 dir readback", v, 32'hFFFF_00FF);
        bus_write(IDX_EMASK, 32'h1234_0000);
        bus_read(IDX_EMASK, v); check("R10 emask readback", v, 32'h1234_0000);
        bus_write(IDX_LMASK, 32'h0000_8765);
        bus_read(IDX_LMASK, v); check("R10 lmask readback", v, 32'h0000_8765);
        bus_write(IDX_EMASK, '0);
        bus_write(IDX_LMASK, '0);
    endtask

    task automatic t_blink_unmapped();
        logic [31:0] v;
        bus_write(IDX_BLINK, 32'hA5A5_5A5A);
        check("R9 blink no pin_out effect", pin_out, 32'h0F0F_0F0F);
        check("R9 blink no pin_oe effect", pin_oe, 32'h0000_FF00);
        bus_read(IDX_BLINK, v); check("R9 blink readback", v, 32'hA5A5_5A5A);
        bus_read(9, v);  check("R9 unmapped 9", v, '0);
        bus_read(15, v); check("R9 unmapped 15", v, '0);
    endtask

    task automatic t_data_in();
        logic [31:0] v;
        pin_in = 32'h1234_5678;
        @(negedge clk);
        bus_read(IDX_DIN, v); check("R3 din after two edges", v, 32'h1234_5678);
        bus_write(IDX_INV, 32'hFFFF_0000);
        bus_read(IDX_INV, v); check("R10 inv readback", v, 32'hFFFF_0000);
        bus_read(IDX_DIN, v); check("R3 din inverted", v, 32'hEDCB_5678);
        quiet_all();
    endtask

    task automatic t_edge_basic();
        logic [31:0] v;
        pin_in[3] = 1'b1; pin_in[10] = 1'b1;
        settle_pins();
        bus_read(IDX_ECAUSE, v); check("R5 rise sets cause", v, 32'h0000_0408);
        pin_in = '0;
        settle_pins();
        bus_read(IDX_ECAUSE, v); check("R5 cause sticky", v, 32'h0000_0408);
        bus_write(IDX_ECAUSE, ~32'h0000_0008);
        bus_read(IDX_ECAUSE, v); check("R6 clear only zero bits", v, 32'h0000_0400);
        bus_write(IDX_ECAUSE, 32'hFFFF_FFFF);
        bus_read(IDX_ECAUSE, v); check("R6 all-ones write keeps", v, 32'h0000_0400);
        bus_write(IDX_ECAUSE, '0);
        bus_read(IDX_ECAUSE, v); check("R6 zero write clears", v, '0);
    endtask

    task automatic t_edge_falling();
        logic [31:0] v;
        bus_write(IDX_INV, 32'h0000_0020);
        settle_pins();
        bus_write(IDX_ECAUSE, '0);
        pin_in[5] = 1'b1;
        settle_pins();
        bus_read(IDX_ECAUSE, v); check("R5 inverted rising ignored", v, '0);
        pin_in[5] = 1'b0;
        settle_pins();
        bus_read(IDX_ECAUSE, v); check("R5 inverted falling sets", v, 32'h0000_0020);
        quiet_all();
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        pin_in[7] = 1'b1;
        @(negedge clk);
        bus_write(IDX_ECAUSE, '0);
        bus_read(IDX_ECAUSE, v); check("R7 edge beats clear", v, 32'h0000_0080);
        bus_write(IDX_ECAUSE, '0);
        bus_read(IDX_ECAUSE, v); check("R7 later clear works", v, '0);
        quiet_all();
    endtask

    task automatic t_level();
        bus_write(IDX_LMASK, 32'h0000_1000);
        pin_in[12] = 1'b1;
        settle_pins();
        check("R4 level high raises group 1", {28'd0, irq_grp}, 32'h2);
        pin_in[12] = 1'b0;
        settle_pins();
        check("R4 level drops", {28'd0, irq_grp}, 32'h0);
        bus_write(IDX_INV, 32'h0000_1000);
        check("R4 inverted low raises", {28'd0, irq_grp}, 32'h2);
        quiet_all();
    endtask

    task automatic t_groups();
        bus_write(IDX_LMASK, 32'hFFFF_FFFF);
        for (int g = 0; g < 4; g++) begin
            pin_in = 32'h1 << (g * 8 + 7);
            settle_pins();
            check($sformatf("R8 group %0d top line", g), {28'd0, irq_grp}, 32'h1 << g);
            pin_in = 32'h1 << (g * 8);
            settle_pins();
            check($sformatf("R8 group %0d bottom line", g), {28'd0, irq_grp}, 32'h1 << g);
        end
        quiet_all();
    endtask

    task automatic t_edge_mask();
        pin_in[30] = 1'b1;
        settle_pins();
        check("R11 unmasked edge quiet", {28'd0, irq_grp}, 32'h0);
        bus_write(IDX_EMASK, 32'h4000_0000);
        check("R5 masked edge raises group 3", {28'd0, irq_grp}, 32'h8);
        bus_write(IDX_ECAUSE, ~32'h4000_0000);
        check("R6 ack drops group 3", {28'd0, irq_grp}, 32'h0);
        quiet_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_regs_dir();
        t_blink_unmapped();
        t_data_in();
        t_edge_basic();
        t_edge_falling();
        t_set_wins();
        t_level();
        t_groups();
        t_edge_mask();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule